// File: doc/BRIEF.md
# Bus Clock Ratio Generator

This block runs on the fast core clock and derives two clock-enable strobes from it. One strobe is for a high-speed bus and one is for a slower peripheral bus. Each strobe is a single core-cycle pulse, so downstream logic stays on the core clock and qualifies its flops with the pulse. The high-speed ratio comes from a non-power-of-two set. The peripheral strobe is derived from the high-speed strobe, not directly from the core clock.

A small register port configures the block. It has three registers: a divider register, an extension register that holds one ratio-doubling bit, and a gate register with one enable bit per downstream unit. Each gated unit output is its bus strobe ANDed with that unit's gate bit.

A ratio written to the registers does not take effect at once. It is loaded into the active counters only on a cycle where both derived counters finish their period together. Because of this, no strobe period is ever cut short. The register port is plain control: a write strobe with a select, and a combinational read selected by a separate select. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_clk_ratio_gen`

## Requirements
- R1: The divider register (select 0) bits [2:1] set the high-speed period in core cycles: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 3.
- R2: Extension register (select 1) bit 9 changes the code-2 period from 4 to 8 core cycles when set. It has no effect for codes 0, 1 and 3.
- R3: Divider register bit 0 set to 0 makes the peripheral strobe equal the high-speed strobe. Set to 1, the peripheral strobe fires on every second high-speed strobe.
- R4: `hs_en` is high for exactly one core cycle, the last cycle of each high-speed period. `pb_en` is high only in cycles where `hs_en` is also high.
- R5: Divider value 0x5 with the extension bit clear gives a core : high-speed : peripheral rate ratio of 8 : 2 : 1. In that setting `hs_en` fires every 4th core cycle and `pb_en` fires every 8th.
- R6: Gate register (select 2) bits 4..7 enable `hs_unit_en[0..3]` and bits 8..18 enable `pb_unit_en[0..10]`. A set bit passes the bus strobe through to that unit; a clear bit holds the output at 0.
- R7: New ratio settings are loaded only at the end of a cycle in which both the high-speed period and the peripheral period end. Counting then restarts from the first cycle of the new period.
- R8: After reset the divider and extension registers are 0 and all gate bits are 1, so `hs_en`, `pb_en` and every unit output are high on every core cycle.
- R9: Reads return exactly the written value in the defined bits (select 0: bits 2..0, select 1: bit 9, select 2: bits 18..4). All other bits read 0. Select 3 reads 0, and writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divider, 1 extension, 2 gate, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| hs_en | output | 1 | High-speed bus clock enable |
| pb_en | output | 1 | Peripheral bus clock enable |
| hs_unit_en | output | 4 | Gated high-speed enables, one per unit |
| pb_unit_en | output | 11 | Gated peripheral enables, one per unit |

## Verification
The assertions assume that `wr_sel` and `wr_data` are stable whenever `wr_en` is high at a clock edge. They also assume that reset is released away from the clock edge. The stimulus drives every input half a cycle before the edge that samples it, and moves reset only in the low phase of the clock. Ratio writes are placed at arbitrary phases of a running period, including mid-period, so the assertions that hold reloads to common wrap points see both aligned and unaligned requests.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int DIV_CNT_W = 3;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_GATE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [DIV_CNT_W-1:0] hs_last;  // period minus one, in core cycles
    logic                 pb_half;  // peripheral runs at half the high-speed rate
  } ratio_cfg_t;

  function automatic ratio_cfg_t decode_ratio(input logic [2:0] div, input logic dbl);
    ratio_cfg_t c;
    c.pb_half = div[0];
    unique case (div[2:1])
      2'd0:    c.hs_last = DIV_CNT_W'(0);
      2'd1:    c.hs_last = DIV_CNT_W'(1);
      2'd2:    c.hs_last = dbl ? DIV_CNT_W'(7) : DIV_CNT_W'(3);
      default: c.hs_last = DIV_CNT_W'(2);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 3,
  parameter int EXT_BIT     = 9,
  parameter int GATE_LSB    = 4,
  parameter int GATE_MSB    = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [1:0]               rd_sel,
  output logic [DATA_W-1:0]        rd_data,
  output logic [DIV_W-1:0]         div_q,
  output logic                     ext_q,
  output logic [GATE_MSB:GATE_LSB] gate_q
);

  reg_sel_e wsel, rsel;
  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ext_q  <= 1'b0;
      gate_q <= '1;
    end else if (wr_en) begin
      case (wsel)
        SEL_DIV:  div_q  <= wr_data[DIV_W-1:0];
        SEL_EXT:  ext_q  <= wr_data[EXT_BIT];
        SEL_GATE: gate_q <= wr_data[GATE_MSB:GATE_LSB];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_DIV:  rd_data[DIV_W-1:0]         = div_q;
      SEL_EXT:  rd_data[EXT_BIT]           = ext_q;
      SEL_GATE: rd_data[GATE_MSB:GATE_LSB] = gate_q;
      default:  rd_data = '0;
    endcase
  end

  AST_WR_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_DIV) |=> (div_q == $past(wr_data[DIV_W-1:0]))); // R9

  AST_WR_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_GATE) |=> (gate_q == $past(wr_data[GATE_MSB:GATE_LSB]))); // R6

endmodule

// File: rtl/bcr_ratio_ctrl.sv
module bcr_ratio_ctrl
  import bcr_pkg::*;
#(
  parameter int CNT_W = DIV_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_cfg,
  input  logic       dbl_cfg,
  output logic       hs_en,
  output logic       pb_en
);

  ratio_cfg_t       act_q, pend;
  logic [CNT_W-1:0] hs_cnt;
  logic             pb_cnt;
  logic             hs_wrap, pb_wrap, wrap;

  assign pend    = decode_ratio(div_cfg, dbl_cfg);
  assign hs_wrap = (hs_cnt == act_q.hs_last);
  assign pb_wrap = !act_q.pb_half || pb_cnt;
  assign wrap    = hs_wrap && pb_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      hs_cnt <= '0;
      pb_cnt <= 1'b0;
    end else if (wrap) begin
      act_q  <= pend;
      hs_cnt <= '0;
      pb_cnt <= 1'b0;
    end else if (hs_wrap) begin
      hs_cnt <= '0;
      pb_cnt <= ~pb_cnt;
    end else begin
      hs_cnt <= hs_cnt + 1'b1;
    end
  end

  assign hs_en = hs_wrap;
  assign pb_en = wrap;

  AST_CFG_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(wrap)); // R7

  AST_LOAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (act_q == $past(pend) && hs_cnt == '0)); // R7

  AST_HS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !wrap && act_q.hs_last != '0) |=> !hs_en); // R4

endmodule

// File: rtl/bcr_gate.sv
module bcr_gate #(
  parameter int N = 4
) (
  input  logic         en,
  input  logic [N-1:0] mask,
  output logic [N-1:0] unit_en
);

  for (genvar i = 0; i < N; i++) begin : g_unit
    assign unit_en[i] = en & mask[i];
  end

endmodule

// File: rtl/bus_clk_ratio_gen.sv
module bus_clk_ratio_gen
  import bcr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HS_GATES    = 4,
  parameter int PB_GATES    = 11,
  parameter int HS_GATE_LSB = 4,
  parameter int EXT_BIT     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic                hs_en,
  output logic                pb_en,
  output logic [HS_GATES-1:0] hs_unit_en,
  output logic [PB_GATES-1:0] pb_unit_en
);

  localparam int PB_GATE_LSB = HS_GATE_LSB + HS_GATES;
  localparam int GATE_MSB    = PB_GATE_LSB + PB_GATES - 1;
  localparam int DIV_W       = 3;

  logic [DIV_W-1:0]           div_q;
  logic                       ext_q;
  logic [GATE_MSB:HS_GATE_LSB] gate_q;

  bcr_regs #(
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .EXT_BIT (EXT_BIT),
    .GATE_LSB(HS_GATE_LSB),
    .GATE_MSB(GATE_MSB)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .div_q  (div_q),
    .ext_q  (ext_q),
    .gate_q (gate_q)
  );

  bcr_ratio_ctrl #(.CNT_W(DIV_CNT_W)) u_ratio (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_cfg(div_q),
    .dbl_cfg(ext_q),
    .hs_en  (hs_en),
    .pb_en  (pb_en)
  );

  bcr_gate #(.N(HS_GATES)) u_hs_gate (
    .en     (hs_en),
    .mask   (gate_q[PB_GATE_LSB-1:HS_GATE_LSB]),
    .unit_en(hs_unit_en)
  );

  bcr_gate #(.N(PB_GATES)) u_pb_gate (
    .en     (pb_en),
    .mask   (gate_q[GATE_MSB:PB_GATE_LSB]),
    .unit_en(pb_unit_en)
  );

  AST_PB_WITHIN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    pb_en |-> hs_en); // R4

endmodule

// File: tb/tb_bus_clk_ratio_gen.sv
`timescale 1ns/1ps
module tb_bus_clk_ratio_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        hs_en, pb_en;
  logic [3:0]  hs_unit_en;
  logic [10:0] pb_unit_en;

  bus_clk_ratio_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .hs_en(hs_en), .pb_en(pb_en),
    .hs_unit_en(hs_unit_en), .pb_unit_en(pb_unit_en)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  bit    finished = 1'b0;
  string cur_req  = "R8";

  // behavioural reference state
  int m_div = 0, m_x = 0, m_gate = 32'h7FFF0;
  int hsd = 1, pbm = 1, phase = 0;

  function automatic int hs_period(int d, int x);
    case ((d >> 1) & 3)
      0: return 1;
      1: return 2;
      2: return x ? 8 : 4;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_x = 0; m_gate = 32'h7FFF0; hsd = 1; pbm = 1; phase = 0;
    end else begin
      if (phase == hsd * pbm - 1) begin
        hsd = hs_period(m_div, m_x);
        pbm = (m_div & 1) ? 2 : 1;
        phase = 0;
      end else begin
        phase++;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_div = wr_data & 7;
          2'd1: m_x = (wr_data >> 9) & 1;
          2'd2: m_gate = wr_data & 32'h7FFF0;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic        e_hs, e_pb;
      logic [3:0]  e_hsu;
      logic [10:0] e_pbu;
      e_hs = ((phase + 1) % hsd) == 0;
      e_pb = ((phase + 1) % (hsd * pbm)) == 0;
      for (int i = 0; i < 4; i++)  e_hsu[i] = e_hs & m_gate[4 + i];
      for (int j = 0; j < 11; j++) e_pbu[j] = e_pb & m_gate[8 + j];
      n_checks++;
      if ({hs_en, pb_en, hs_unit_en, pb_unit_en} !== {e_hs, e_pb, e_hsu, e_pbu}) begin
        n_fail++;
        $display("FAIL %s cycle %0d: hs=%b pb=%b hsu=%b pbu=%b expected hs=%b pb=%b hsu=%b pbu=%b",
                 cur_req, cycles, hs_en, pb_en, hs_unit_en, pb_unit_en, e_hs, e_pb, e_hsu, e_pbu);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_sel = s;
    #1;
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s read sel %0d: got %h expected %h", req, s, rd_data, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #2 rst_n = 1'b0;
    run(3);
    @(negedge clk); #2 rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    cur_req = "R8"; run(6);
    rd_check(2'd0, 32'h0, "R8");
    rd_check(2'd1, 32'h0, "R8");
    rd_check(2'd2, 32'h0007_FFF0, "R8");

    cur_req = "R1"; wr(2'd0, 32'h2); run(12);
    wr(2'd0, 32'h4); run(16);
    wr(2'd0, 32'h6); run(15);
    wr(2'd0, 32'h0); run(6);

    cur_req = "R2"; wr(2'd1, 32'h200); wr(2'd0, 32'h4); run(26);
    wr(2'd0, 32'h2); run(10);
    wr(2'd0, 32'h6); run(12);
    wr(2'd1, 32'h0); run(10);

    cur_req = "R5"; wr(2'd0, 32'h5); run(32);

    cur_req = "R3"; wr(2'd0, 32'h1); run(10);
    wr(2'd0, 32'h7); run(18);
    wr(2'd0, 32'h3); run(10);

    cur_req = "R7"; wr(2'd1, 32'h200); wr(2'd0, 32'h5); run(5);
    wr(2'd0, 32'h0); run(3);
    wr(2'd0, 32'h7); run(2);
    wr(2'd0, 32'h2); wr(2'd0, 32'h4); run(20);
    wr(2'd1, 32'h0); run(9);

    cur_req = "R6"; wr(2'd0, 32'h3);
    wr(2'd2, 32'h0000_0050); run(12);
    wr(2'd2, 32'h0005_5A00); run(12);
    wr(2'd2, 32'h0); run(8);
    wr(2'd2, 32'hFFFF_FFFF); run(8);

    cur_req = "R9";
    wr(2'd0, 32'hFFFF_FFF8); rd_check(2'd0, 32'h0, "R9");
    wr(2'd0, 32'hFFFF_FFFD); rd_check(2'd0, 32'h5, "R9");
    wr(2'd1, 32'hFFFF_FFFF); rd_check(2'd1, 32'h200, "R9");
    wr(2'd2, 32'hA5A5_A5A5); rd_check(2'd2, 32'h0005_A5A0, "R9");
    wr(2'd3, 32'h0000_0000); rd_check(2'd3, 32'h0, "R9");
    rd_check(2'd0, 32'h5, "R9");
    rd_check(2'd1, 32'h200, "R9");
    rd_check(2'd2, 32'h0005_A5A0, "R9");
    run(20);

    do_reset();
    cur_req = "R8"; run(4);
    rd_check(2'd0, 32'h0, "R8");
    rd_check(2'd2, 32'h0007_FFF0, "R8");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule